// File: doc/BRIEF.md
# Serial Command Port for an 8-bit Converter Pair

This block is the device side of a four-wire serial link. The host drives a select line that is active low, a serial clock and a data line. The block answers on a data-out line that has its own output enable. The select line, the serial clock and the data line are first brought through a synchronizer into the system clock, and edges are found on the synchronized copies. The block then works as a mode-0 slave: it samples input on the rising serial edge and moves its output on the falling serial edge.

Zero bits that arrive before a start bit are skipped. The first one bit opens an 8-bit command byte. The byte is decoded into converter settings. When the digital-to-analog side is addressed, the byte that follows goes into a double-buffered output code register. When the analog-to-digital side is addressed and enabled, the block sends a conversion-start strobe to the converter sequencer. It then shifts the 8-bit result from the sequencer out MSB first. The sequencer can run in one-shot or free-running mode. A rise of the select line is treated differently depending on what it interrupts.

Top module: `serial_codec_port`

## Requirements
- R1: `ser_out_oe` is 0 while `chip_sel_n` is high and 1 while it is low. Result bits change only after falling edges of `ser_clk`, so each bit is stable across the following rising edge.
- R2: With select low, any number of 0 bits before the first 1 are ignored. That 1 is bit 7 of the command byte.
- R3: The command byte decodes as follows: bit 6 addresses the DAC (`sel_dac`), bit 5 addresses the ADC (`sel_adc`), bit 4 selects the half-supply input (`in_half`), bit 3 selects free-running mode (`cont_mode`), bit 2 enables the reference (`ref_en`), bit 1 enables the ADC (`adc_en`) and bit 0 enables the DAC (`dac_en`). All seven fields are 0 after reset.
- R4: After a command byte with bit 6 set, the next 8 bits (MSB first) are DAC data. If bit 0 was set, `dac_code` takes the new value with a one-cycle `dac_load` pulse only after the eighth data bit.
- R5: DAC data received while `dac_en` is 0 is held and does not reach `dac_code`. A later command byte with bit 0 set moves the held value to `dac_code` with a `dac_load` pulse.
- R6: In free-running DAC mode, every further group of 8 bits is loaded into `dac_code`. A rise of select ends the mode, and 0 bits sent after the next fall load nothing.
- R7: A rise of select part-way through a command byte clears all seven decoded fields to 0.
- R8: A rise of select part-way through DAC data discards the partial bits. `dac_code` and the decoded fields are left unchanged.
- R9: A command byte with bits 5 and 1 set causes exactly one `conv_start` pulse on the falling serial edge after its last bit. The `adc_data` value captured at `adc_done` is shifted out MSB first over the next 8 serial clocks. In one-shot mode no further pulse follows.
- R10: If select rises during result readout, shifting stops. After select falls again, the remaining bits continue from where they stopped.
- R11: In free-running ADC mode, the falling edge that ends the eighth result bit issues a new `conv_start`. A new command byte reconfigures the port, and one that clears bit 5 stops further conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial data from the host |
| ser_out | output | 1 | Serial result data |
| ser_out_oe | output | 1 | Output enable for `ser_out` (three-state control) |
| adc_data | input | 8 | Conversion result from the sequencer |
| adc_done | input | 1 | One-cycle strobe: `adc_data` is valid |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| dac_code | output | 8 | Code presented to the DAC |
| dac_load | output | 1 | One-cycle strobe when `dac_code` changes |
| sel_dac | output | 1 | Decoded DAC address bit |
| sel_adc | output | 1 | Decoded ADC address bit |
| in_half | output | 1 | Decoded input select (1 = half supply) |
| cont_mode | output | 1 | Decoded free-running mode |
| ref_en | output | 1 | Decoded reference enable |
| adc_en | output | 1 | Decoded ADC enable |
| dac_en | output | 1 | Decoded DAC enable |

## Verification
The bench covers each point where select can be cut short. A cut inside a command byte that left the fields alone would show stale enables. A cut inside DAC data that kept the partial bits would load a corrupted code. A readout that restarted after a pause would return a rotated byte instead of the captured result. Further tests send leading zeros, which a port that framed on the first edge would misalign, and write DAC data while the DAC is disabled, which a single-buffered port would either lose or apply too early. The free-running tests count conversion strobes, so an extra or missing relaunch, or one that survives a reconfiguring byte, changes the count.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  localparam int CMD_W = 8;

  // Field order matches command byte bits 6..0.
  typedef struct packed {
    logic dac_sel;
    logic adc_sel;
    logic in_half;
    logic cont;
    logic ref_en;
    logic adc_en;
    logic dac_en;
  } cmd_t;

  typedef enum logic [1:0] {RX_HUNT, RX_CMD, RX_DATA} rx_st_t;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SHIFT} tx_st_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
  import codec_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clk_rise,
  input  logic          clk_fall,
  input  logic          cs_rise,
  input  logic          din,
  output cmd_t          cfg,
  output logic [DW-1:0] dac_code,
  output logic          dac_load,
  output logic          adc_kick
);
  localparam int SRW = (DW > CMD_W) ? DW : CMD_W;
  localparam int CW  = $clog2(SRW);
  localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_W - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DW - 1);

  rx_st_t          state;
  logic [SRW-2:0]  sr;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   hold;
  logic            held_pend;
  logic            kick_pend;
  logic [SRW-1:0]  nxt;
  cmd_t            new_cfg;

  always_comb begin
    nxt     = {sr, din};
    new_cfg = cmd_t'(nxt[CMD_W-2:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_HUNT;
      sr        <= '0;
      cnt       <= '0;
      hold      <= '0;
      held_pend <= 1'b0;
      kick_pend <= 1'b0;
      cfg       <= '0;
      dac_code  <= '0;
      dac_load  <= 1'b0;
      adc_kick  <= 1'b0;
    end else begin
      dac_load <= 1'b0;
      adc_kick <= 1'b0;
      if (cs_rise) begin
        if (state == RX_CMD) cfg <= '0;
        state     <= RX_HUNT;
        cnt       <= '0;
        kick_pend <= 1'b0;
      end else begin
        if (clk_fall && kick_pend) begin
          kick_pend <= 1'b0;
          adc_kick  <= 1'b1;
        end
        if (clk_rise) begin
          unique case (state)
            RX_HUNT: begin
              if (din) begin
                sr    <= nxt[SRW-2:0];
                cnt   <= CW'(1);
                state <= RX_CMD;
              end
            end
            RX_CMD: begin
              sr <= nxt[SRW-2:0];
              if (cnt == CMD_LAST) begin
                cfg <= new_cfg;
                cnt <= '0;
                if (new_cfg.dac_en && held_pend) begin
                  dac_code  <= hold;
                  dac_load  <= 1'b1;
                  held_pend <= 1'b0;
                end
                if (new_cfg.adc_sel && new_cfg.adc_en) kick_pend <= 1'b1;
                state <= new_cfg.dac_sel ? RX_DATA : RX_HUNT;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            RX_DATA: begin
              sr <= nxt[SRW-2:0];
              if (cnt == DATA_LAST) begin
                hold <= nxt[DW-1:0];
                cnt  <= '0;
                if (cfg.dac_en) begin
                  dac_code  <= nxt[DW-1:0];
                  dac_load  <= 1'b1;
                  held_pend <= 1'b0;
                end else begin
                  held_pend <= 1'b1;
                end
                state <= cfg.cont ? RX_DATA : RX_HUNT;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: state <= RX_HUNT;
          endcase
        end
      end
    end
  end

  // R7
  abort_cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_CMD && cs_rise) |=> (cfg == '0));

  // R8
  abort_data_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA && cs_rise) |=> (state == RX_HUNT && $stable(dac_code) && !dac_load));

  // R4
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load);
endmodule

// File: rtl/result_tx.sv
module result_tx
  import codec_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          clk_fall,
  input  logic          kick,
  input  logic          relaunch_ok,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          conv_start
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tx_st_t        state;
  logic [DW-1:0] shreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= TX_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      conv_start <= 1'b0;
      sdo_oe     <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      sdo_oe     <= sel;
      if (kick) begin
        state      <= TX_WAIT;
        conv_start <= 1'b1;
        shreg      <= '0;
        cnt        <= '0;
      end else begin
        unique case (state)
          TX_WAIT: begin
            if (adc_done) begin
              shreg <= adc_data;
              cnt   <= '0;
              state <= TX_SHIFT;
            end
          end
          TX_SHIFT: begin
            if (clk_fall) begin
              if (cnt == LAST) begin
                shreg <= '0;
                cnt   <= '0;
                if (relaunch_ok) begin
                  conv_start <= 1'b1;
                  state      <= TX_WAIT;
                end else begin
                  state <= TX_IDLE;
                end
              end else begin
                shreg <= {shreg[DW-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
              end
            end
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  assign sdo = shreg[DW-1];

  // R1
  hiz_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !sdo_oe);

  // R10
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == TX_SHIFT && !sel && !kick) |=> ($stable(shreg) && $stable(cnt)));

  // R9
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
endmodule

// File: rtl/serial_codec_port.sv
module serial_codec_port
  import codec_port_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_sel_n,
  input  logic          ser_clk,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          ser_out_oe,
  input  logic [DW-1:0] adc_data,
  input  logic          adc_done,
  output logic          conv_start,
  output logic [DW-1:0] dac_code,
  output logic          dac_load,
  output logic          sel_dac,
  output logic          sel_adc,
  output logic          in_half,
  output logic          cont_mode,
  output logic          ref_en,
  output logic          adc_en,
  output logic          dac_en
);
  logic [2:0] sq;
  logic       cs_prev, clk_prev;
  logic       sel, cs_rise, clk_rise, clk_fall;
  logic       adc_kick;
  cmd_t       cfg;

  sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({chip_sel_n, ser_clk, ser_in}),
    .q   (sq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev  <= 1'b1;
      clk_prev <= 1'b0;
    end else begin
      cs_prev  <= sq[2];
      clk_prev <= sq[1];
    end
  end

  assign sel      = ~sq[2];
  assign cs_rise  = sq[2] & ~cs_prev;
  assign clk_rise = sel & sq[1] & ~clk_prev;
  assign clk_fall = sel & ~sq[1] & clk_prev;

  cmd_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clk_rise (clk_rise),
    .clk_fall (clk_fall),
    .cs_rise  (cs_rise),
    .din      (sq[0]),
    .cfg      (cfg),
    .dac_code (dac_code),
    .dac_load (dac_load),
    .adc_kick (adc_kick)
  );

  result_tx #(.DW(DW)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .clk_fall    (clk_fall),
    .kick        (adc_kick),
    .relaunch_ok (cfg.cont && cfg.adc_sel && cfg.adc_en),
    .adc_done    (adc_done),
    .adc_data    (adc_data),
    .sdo         (ser_out),
    .sdo_oe      (ser_out_oe),
    .conv_start  (conv_start)
  );

  assign sel_dac   = cfg.dac_sel;
  assign sel_adc   = cfg.adc_sel;
  assign in_half   = cfg.in_half;
  assign cont_mode = cfg.cont;
  assign ref_en    = cfg.ref_en;
  assign adc_en    = cfg.adc_en;
  assign dac_en    = cfg.dac_en;
endmodule

// File: tb/tb_serial_codec_port.sv
module tb_serial_codec_port;
  localparam int HALF = 8;
  // {cmd[7:0], data[7:0], has_data, exp_code[7:0], exp_loads[1:0]}
  localparam logic [26:0] VEC [4] = '{
    {8'hC1, 8'h5A, 1'b1, 8'h5A, 2'd1},
    {8'hC0, 8'h33, 1'b1, 8'h5A, 2'd0},
    {8'h81, 8'h00, 1'b0, 8'h33, 2'd1},
    {8'hC5, 8'hFF, 1'b1, 8'hFF, 2'd1}
  };
  localparam logic [7:0] RES [5] = '{8'h96, 8'hC3, 8'h5C, 8'hE7, 8'h3D};

  logic clk = 1'b0, rst = 1'b1;
  logic chip_sel_n = 1'b1, ser_clk = 1'b0, ser_in = 1'b0;
  logic ser_out, ser_out_oe, conv_start, dac_load;
  logic [7:0] adc_data = 8'h00, dac_code;
  logic adc_done = 1'b0;
  logic sel_dac, sel_adc, in_half, cont_mode, ref_en, adc_en, dac_en;
  logic [6:0] cfg_now;
  int total = 0, fails = 0, loads = 0, convs = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_codec_port dut (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .ser_out(ser_out), .ser_out_oe(ser_out_oe), .adc_data(adc_data), .adc_done(adc_done),
    .conv_start(conv_start), .dac_code(dac_code), .dac_load(dac_load),
    .sel_dac(sel_dac), .sel_adc(sel_adc), .in_half(in_half), .cont_mode(cont_mode),
    .ref_en(ref_en), .adc_en(adc_en), .dac_en(dac_en)
  );

  assign cfg_now = {sel_dac, sel_adc, in_half, cont_mode, ref_en, adc_en, dac_en};

  always @(negedge clk) begin
    if (dac_load) loads <= loads + 1;
    if (conv_start) convs <= convs + 1;
  end

  // Sequencer model: result follows a start strobe after 20 cycles.
  initial begin
    int idx = 0;
    forever begin
      @(negedge clk);
      if (conv_start) begin
        repeat (20) @(negedge clk);
        adc_data = RES[idx % 5];
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        idx++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic so);
    ser_in = b;
    repeat (HALF) @(negedge clk);
    so = ser_out;
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic byte_xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic so;
      bit_xfer(tx[i], so);
      rx[i] = so;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_low();
    chip_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_high();
    repeat (HALF) @(negedge clk);
    chip_sel_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rx, part;
    logic so;
    int l0, c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // Reset state
    chk("R1 reset oe", ser_out_oe, 0);
    chk("R3 reset fields", cfg_now, 0);
    chk("R4 reset code", dac_code, 0);

    // Vector table: DAC writes, field decode, double buffering
    for (int i = 0; i < 4; i++) begin
      logic [26:0] v;
      v = VEC[i];
      l0 = loads;
      sel_low();
      chk("R1 oe while selected", ser_out_oe, 1);
      byte_xfer(v[26:19], rx);
      if (v[10]) byte_xfer(v[18:11], rx);
      sel_high();
      chk("R3 fields", cfg_now, v[25:19]);
      chk("R4/R5 dac code", dac_code, v[9:2]);
      chk("R4/R5 load count", loads - l0, v[1:0]);
    end
    chk("R1 oe after deselect", ser_out_oe, 0);

    // R2: leading zeros
    sel_low();
    for (int i = 0; i < 3; i++) bit_xfer(1'b0, so);
    byte_xfer(8'hC1, rx);
    byte_xfer(8'h12, rx);
    sel_high();
    chk("R2 leading zeros", dac_code, 8'h12);

    // R8: abort inside DAC data
    l0 = loads;
    sel_low();
    byte_xfer(8'hC1, rx);
    bit_xfer(1'b1, so); bit_xfer(1'b0, so); bit_xfer(1'b1, so); bit_xfer(1'b0, so);
    sel_high();
    chk("R8 code kept", dac_code, 8'h12);
    chk("R8 fields kept", cfg_now, 7'h41);
    sel_low();
    byte_xfer(8'h00, rx);
    sel_high();
    chk("R8 no load", loads - l0, 0);

    // R7: abort inside command byte
    sel_low();
    byte_xfer(8'h87, rx);
    chk("R7 fields before abort", cfg_now, 7'h07);
    bit_xfer(1'b1, so); bit_xfer(1'b1, so); bit_xfer(1'b0, so); bit_xfer(1'b0, so);
    sel_high();
    chk("R7 fields cleared", cfg_now, 0);

    // R6: free-running DAC
    l0 = loads;
    sel_low();
    byte_xfer(8'hC9, rx);
    byte_xfer(8'h11, rx); chk("R6 first code", dac_code, 8'h11);
    byte_xfer(8'h22, rx); chk("R6 second code", dac_code, 8'h22);
    byte_xfer(8'h33, rx); chk("R6 third code", dac_code, 8'h33);
    sel_high();
    chk("R6 load count", loads - l0, 3);
    sel_low();
    byte_xfer(8'h00, rx);
    sel_high();
    chk("R6 exited", dac_code, 8'h33);
    chk("R6 no load after exit", loads - l0, 3);

    // R9: one-shot ADC
    c0 = convs;
    sel_low();
    byte_xfer(8'hA2, rx);
    chk("R9 one start", convs - c0, 1);
    repeat (40) @(negedge clk);
    byte_xfer(8'h00, rx);
    chk("R9 result", rx, RES[0]);
    repeat (40) @(negedge clk);
    chk("R9 no relaunch", convs - c0, 1);
    sel_high();

    // R10: paused readout
    sel_low();
    byte_xfer(8'hA2, rx);
    repeat (40) @(negedge clk);
    for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, so); part[i] = so; end
    sel_high();
    chk("R1 oe during pause", ser_out_oe, 0);
    sel_low();
    for (int i = 4; i >= 0; i--) begin bit_xfer(1'b0, so); part[i] = so; end
    chk("R10 resumed result", part, RES[1]);
    sel_high();

    // R11: free-running ADC and reconfiguration
    c0 = convs;
    sel_low();
    byte_xfer(8'hAA, rx);
    repeat (40) @(negedge clk);
    byte_xfer(8'h00, rx);
    chk("R11 first result", rx, RES[2]);
    chk("R11 relaunch", convs - c0, 2);
    repeat (40) @(negedge clk);
    byte_xfer(8'h00, rx);
    chk("R11 second result", rx, RES[3]);
    repeat (40) @(negedge clk);
    byte_xfer(8'h82, rx);
    chk("R11 third result", rx, RES[4]);
    chk("R11 reconfigured", cfg_now, 7'h02);
    repeat (60) @(negedge clk);
    chk("R11 stopped", convs - c0, 3);
    sel_high();

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule